// File: doc/BRIEF.md
# CPU Mode and Trap Controller

This block keeps the 8-bit mode and status byte of a small 8-bit processor core that has a compatibility mode and a native mode. It also runs the entry sequence of the fault trap. The core tells it about two kinds of fault with single-cycle strobes: an undefined opcode was fetched, or a division had a zero divisor. The core also forwards the two instructions that touch the byte: a mode load with an immediate value, and a mode test with an immediate mask. A mode test returns the flag result of the AND and then clears the sticky fault causes.

When a fault arrives while no trap is running, the block steps the core through the register save. It does this one byte per cycle, naming on `push_reg` and `push_hi` which register byte goes onto the descending system stack next. The list of registers depends on the mode in force when the trap began. After the save, the block presents the trap vector address for one cycle and pulses `trap_done` in that cycle. Bus cycles and stack-pointer arithmetic belong to the core.

The state machine has four states:
- `ST_IDLE` goes to `ST_PUSH_LO` when a fault arrives.
- `ST_PUSH_LO` goes to `ST_PUSH_HI` for a 16-bit register. For an 8-bit register it goes to the next slot's `ST_PUSH_LO`, or to `ST_VECTOR` after the last slot.
- `ST_PUSH_HI` goes to the next slot's `ST_PUSH_LO`, or to `ST_VECTOR` after the last slot.
- `ST_VECTOR` always returns to `ST_IDLE`.

Top module: `cpu_mode_trap_ctrl`

## Requirements
- R1: After reset the mode byte `mode_status` is 0x00, so the core is in compatibility mode. `trap_busy`, `push_valid`, `vec_valid` and `trap_done` are all 0.
- R2: A mode load copies bit 0 of `ld_data` (1 = native) and bit 1 (1 = fast interrupt handled like the normal interrupt) into the same bits of `mode_status` on the next cycle. `native_mode` and `firq_as_irq` mirror those bits. Bits 5:2 always read 0, and the load does not alter bits 7:6.
- R3: A zero-divisor strobe sets bit 7 of `mode_status` and an undefined-opcode strobe sets bit 6, both from the next cycle. Each flag stays set until a mode test clears it.
- R4: One cycle after a mode test strobe, `test_valid` is 1 and `test_zero` equals ((mode_status AND mask) == 0) for the byte held before the test. `test_neg` equals bit 7 of that AND. Bits 7:6 are cleared, unless a fault strobe in the same cycle sets its own flag again.
- R5: A fault seen in `ST_IDLE` starts the save in the next cycle. In compatibility mode, 12 bytes follow, one per cycle, in register order PC, U, Y, X, DP, B, A, CC. The `push_reg` codes are CC=0, A=1, B=2, DP=3, X=4, Y=5, U=6, PC=7, W=8.
- R6: In native mode the save is 14 bytes, in register order PC, U, Y, X, DP, W, B, A, CC.
- R7: Codes 4 to 8 are 16-bit registers. Each one is pushed as two consecutive bytes: low byte first with `push_hi`=0, then high byte with `push_hi`=1. Codes 0 to 3 take one byte with `push_hi`=0.
- R8: In the cycle after the last saved byte, `vec_valid` and `trap_done` are 1 for exactly one cycle with `vec_addr` = 0xFFF0 and `push_valid` = 0. The block is idle on the cycle after that.
- R9: A fault during a running trap only sets its flag and does not start a second save. A mode load during a trap does not change the order of the save already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| illegal_stb | input | 1 | Undefined opcode fetched |
| zdiv_stb | input | 1 | Division with zero divisor |
| ld_stb | input | 1 | Mode load command |
| ld_data | input | 8 | Immediate of the mode load |
| test_stb | input | 1 | Mode test command |
| test_mask | input | 8 | Immediate mask of the mode test |
| mode_status | output | 8 | Mode and status byte |
| native_mode | output | 1 | 1 when native mode is selected |
| firq_as_irq | output | 1 | 1 when fast interrupt behaves like the normal one |
| test_valid | output | 1 | Mode test result valid |
| test_zero | output | 1 | Zero flag of the mode test |
| test_neg | output | 1 | Negative flag of the mode test |
| trap_busy | output | 1 | Trap sequence running |
| push_valid | output | 1 | A register byte is to be pushed this cycle |
| push_reg | output | 4 | Code of the register being pushed |
| push_hi | output | 1 | 1 for the high byte of a 16-bit register |
| vec_valid | output | 1 | Trap vector fetch this cycle |
| vec_addr | output | 16 | Trap vector address |
| trap_done | output | 1 | Pulse in the vector fetch cycle |

## Verification
The bench builds the block with its default parameters: an 8-bit mode byte, 16-bit vector address 0xFFF0. Over all 256 load values, every load is checked. Over all 256 masks, every test is checked against each of the four fault-flag combinations. A complete save runs before each flagged test, so both stacking orders and both fault sources are exercised many times. Directed traps cover a fault and a mode load arriving in the middle of a save, and a test that coincides with a fault.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    localparam int MD_W        = 8;
    localparam int MODE_BIT    = 0;
    localparam int FIRQ_BIT    = 1;
    localparam int ILL_BIT     = 6;
    localparam int ZDIV_BIT    = 7;
    localparam int NATIVE_SLOTS = 9;
    localparam int COMPAT_SLOTS = 8;
    localparam int SLOT_W      = $clog2(NATIVE_SLOTS);

    typedef enum logic [3:0] {
        RC_CC = 4'd0,
        RC_A  = 4'd1,
        RC_B  = 4'd2,
        RC_DP = 4'd3,
        RC_X  = 4'd4,
        RC_Y  = 4'd5,
        RC_U  = 4'd6,
        RC_PC = 4'd7,
        RC_W  = 4'd8
    } stk_reg_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_VECTOR
    } trap_state_e;

    // Register saved in a given slot; compatibility mode skips the W slot.
    function automatic stk_reg_e slot_reg(input logic native, input logic [SLOT_W-1:0] slot);
        logic [SLOT_W-1:0] s;
        s = (!native && slot >= SLOT_W'(5)) ? slot + SLOT_W'(1) : slot;
        case (s)
            SLOT_W'(0): return RC_PC;
            SLOT_W'(1): return RC_U;
            SLOT_W'(2): return RC_Y;
            SLOT_W'(3): return RC_X;
            SLOT_W'(4): return RC_DP;
            SLOT_W'(5): return RC_W;
            SLOT_W'(6): return RC_B;
            SLOT_W'(7): return RC_A;
            default:    return RC_CC;
        endcase
    endfunction

    function automatic logic is_wide(input stk_reg_e r);
        return r inside {RC_X, RC_Y, RC_U, RC_PC, RC_W};
    endfunction

endpackage

// File: rtl/mtc_status_reg.sv
module mtc_status_reg
    import mtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            zdiv_stb,
    input  logic            illegal_stb,
    input  logic            ld_stb,
    input  logic [MD_W-1:0] ld_data,
    input  logic            test_stb,
    input  logic [MD_W-1:0] test_mask,
    output logic [MD_W-1:0] md,
    output logic            test_valid,
    output logic            test_zero,
    output logic            test_neg
);

    logic [MD_W-1:0] md_q;
    logic [MD_W-1:0] md_d;
    logic [MD_W-1:0] and_res;
    logic            tv_q;
    logic            tz_q;
    logic            tn_q;

    assign and_res = md_q & test_mask;

    always_comb begin
        md_d = md_q;
        if (ld_stb) begin
            md_d[MODE_BIT] = ld_data[MODE_BIT];
            md_d[FIRQ_BIT] = ld_data[FIRQ_BIT];
        end
        if (test_stb) begin
            md_d[ZDIV_BIT] = 1'b0;
            md_d[ILL_BIT]  = 1'b0;
        end
        if (zdiv_stb)    md_d[ZDIV_BIT] = 1'b1;
        if (illegal_stb) md_d[ILL_BIT]  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            md_q <= '0;
            tv_q <= 1'b0;
            tz_q <= 1'b0;
            tn_q <= 1'b0;
        end else begin
            md_q <= md_d;
            tv_q <= test_stb;
            if (test_stb) begin
                tz_q <= (and_res == '0);
                tn_q <= and_res[MD_W-1];
            end
        end
    end

    assign md         = md_q;
    assign test_valid = tv_q;
    assign test_zero  = tz_q;
    assign test_neg   = tn_q;

endmodule

// File: rtl/mtc_trap_seq.sv
module mtc_trap_seq
    import mtc_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic              native,
    output logic              busy,
    output logic              push_valid,
    output logic [3:0]        push_reg,
    output logic              push_hi,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              done
);

    localparam logic [SLOT_W-1:0] LAST_NAT = SLOT_W'(NATIVE_SLOTS - 1);
    localparam logic [SLOT_W-1:0] LAST_CMP = SLOT_W'(COMPAT_SLOTS - 1);

    trap_state_e       state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              nat_q, nat_d;
    stk_reg_e          cur_reg;
    logic              cur_wide;
    logic              slot_last;

    assign cur_reg   = slot_reg(nat_q, slot_q);
    assign cur_wide  = is_wide(cur_reg);
    assign slot_last = (slot_q == (nat_q ? LAST_NAT : LAST_CMP));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            nat_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            nat_q   <= nat_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        nat_d   = nat_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fault) begin
                    state_d = ST_PUSH_LO;
                    slot_d  = '0;
                    nat_d   = native;
                end
            end
            ST_PUSH_LO: begin
                if (cur_wide) begin
                    state_d = ST_PUSH_HI;
                end else if (slot_last) begin
                    state_d = ST_VECTOR;
                end else begin
                    slot_d = slot_q + SLOT_W'(1);
                end
            end
            ST_PUSH_HI: begin
                if (slot_last) begin
                    state_d = ST_VECTOR;
                end else begin
                    state_d = ST_PUSH_LO;
                    slot_d  = slot_q + SLOT_W'(1);
                end
            end
            ST_VECTOR: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        push_valid = 1'b0;
        push_hi    = 1'b0;
        push_reg   = 4'd0;
        vec_valid  = 1'b0;
        vec_addr   = '0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PUSH_LO: begin
                push_valid = 1'b1;
                push_reg   = cur_reg;
            end
            ST_PUSH_HI: begin
                push_valid = 1'b1;
                push_hi    = 1'b1;
                push_reg   = cur_reg;
            end
            ST_VECTOR: begin
                vec_valid = 1'b1;
                vec_addr  = VEC_ADDR;
                done      = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cpu_mode_trap_ctrl.sv
module cpu_mode_trap_ctrl
    import mtc_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              illegal_stb,
    input  logic              zdiv_stb,
    input  logic              ld_stb,
    input  logic [7:0]        ld_data,
    input  logic              test_stb,
    input  logic [7:0]        test_mask,
    output logic [7:0]        mode_status,
    output logic              native_mode,
    output logic              firq_as_irq,
    output logic              test_valid,
    output logic              test_zero,
    output logic              test_neg,
    output logic              trap_busy,
    output logic              push_valid,
    output logic [3:0]        push_reg,
    output logic              push_hi,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              trap_done
);

    logic [MD_W-1:0] md;
    logic            fault_any;

    assign fault_any = illegal_stb | zdiv_stb;

    mtc_status_reg u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .zdiv_stb    (zdiv_stb),
        .illegal_stb (illegal_stb),
        .ld_stb      (ld_stb),
        .ld_data     (ld_data),
        .test_stb    (test_stb),
        .test_mask   (test_mask),
        .md          (md),
        .test_valid  (test_valid),
        .test_zero   (test_zero),
        .test_neg    (test_neg)
    );

    mtc_trap_seq #(
        .ADDR_W   (ADDR_W),
        .VEC_ADDR (VEC_ADDR)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault      (fault_any),
        .native     (md[MODE_BIT]),
        .busy       (trap_busy),
        .push_valid (push_valid),
        .push_reg   (push_reg),
        .push_hi    (push_hi),
        .vec_valid  (vec_valid),
        .vec_addr   (vec_addr),
        .done       (trap_done)
    );

    assign mode_status = md;
    assign native_mode = md[MODE_BIT];
    assign firq_as_irq = md[FIRQ_BIT];

endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              illegal_stb,
    input logic              zdiv_stb,
    input logic              ld_stb,
    input logic [7:0]        ld_data,
    input logic              test_stb,
    input logic [7:0]        mode_status,
    input logic              trap_busy,
    input logic              push_valid,
    input logic [3:0]        push_reg,
    input logic              push_hi,
    input logic              vec_valid,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              trap_done
);

    assert_unused_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_status[5:2] == 4'b0000);

    assert_load_mode_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |=> mode_status[1:0] == $past(ld_data[1:0]));

    assert_zdiv_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        zdiv_stb |=> mode_status[7]);

    assert_illegal_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_stb |=> mode_status[6]);

    assert_test_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (test_stb && !zdiv_stb && !illegal_stb) |=> mode_status[7:6] == 2'b00);

    assert_trap_starts_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((zdiv_stb || illegal_stb) && !trap_busy) |=> (push_valid && push_reg == 4'd7 && !push_hi));

    assert_hi_follows_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_hi |-> ($past(push_valid) && !$past(push_hi) && $past(push_reg) == push_reg));

    assert_vector_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done |-> (vec_valid && vec_addr == VEC_ADDR && !push_valid));

    assert_vector_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done |=> !trap_busy);

    assert_no_early_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_busy && !vec_valid) |=> trap_busy);

endmodule

bind cpu_mode_trap_ctrl mtc_checker #(
    .ADDR_W   (ADDR_W),
    .VEC_ADDR (VEC_ADDR)
) u_mtc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .illegal_stb (illegal_stb),
    .zdiv_stb    (zdiv_stb),
    .ld_stb      (ld_stb),
    .ld_data     (ld_data),
    .test_stb    (test_stb),
    .mode_status (mode_status),
    .trap_busy   (trap_busy),
    .push_valid  (push_valid),
    .push_reg    (push_reg),
    .push_hi     (push_hi),
    .vec_valid   (vec_valid),
    .vec_addr    (vec_addr),
    .trap_done   (trap_done)
);

// File: tb/test_cpu_mode_trap_ctrl.sv
`timescale 1ns/1ps
module test_cpu_mode_trap_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        illegal_stb = 1'b0;
    logic        zdiv_stb = 1'b0;
    logic        ld_stb = 1'b0;
    logic [7:0]  ld_data = 8'h00;
    logic        test_stb = 1'b0;
    logic [7:0]  test_mask = 8'h00;
    logic [7:0]  mode_status;
    logic        native_mode;
    logic        firq_as_irq;
    logic        test_valid;
    logic        test_zero;
    logic        test_neg;
    logic        trap_busy;
    logic        push_valid;
    logic [3:0]  push_reg;
    logic        push_hi;
    logic        vec_valid;
    logic [15:0] vec_addr;
    logic        trap_done;

    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;
    logic [7:0] md_m = 8'h00;

    always #2.5 clk = ~clk;

    cpu_mode_trap_ctrl i_cpu_mode_trap_ctrl (
        .clk(clk), .rst_n(rst_n),
        .illegal_stb(illegal_stb), .zdiv_stb(zdiv_stb),
        .ld_stb(ld_stb), .ld_data(ld_data),
        .test_stb(test_stb), .test_mask(test_mask),
        .mode_status(mode_status), .native_mode(native_mode), .firq_as_irq(firq_as_irq),
        .test_valid(test_valid), .test_zero(test_zero), .test_neg(test_neg),
        .trap_busy(trap_busy), .push_valid(push_valid), .push_reg(push_reg),
        .push_hi(push_hi), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .trap_done(trap_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // zd: 1 = zero divisor, 0 = undefined opcode. inject_at: byte index at
    // which a second fault and a mode load to native are driven (-1: none).
    task automatic do_trap(input bit zd, input bit with_tst, input int inject_at);
        bit   nat;
        int   codes[$];
        int   regs_nat[9] = '{7, 6, 5, 4, 3, 8, 2, 1, 0};
        int   regs_cmp[8] = '{7, 6, 5, 4, 3, 2, 1, 0};
        bit   his[$];
        string rq;
        nat = md_m[0];
        rq = nat ? "R6" : "R5";
        if (nat) begin
            foreach (regs_nat[i]) begin
                codes.push_back(regs_nat[i]); his.push_back(1'b0);
                if (regs_nat[i] >= 4) begin codes.push_back(regs_nat[i]); his.push_back(1'b1); end
            end
        end else begin
            foreach (regs_cmp[i]) begin
                codes.push_back(regs_cmp[i]); his.push_back(1'b0);
                if (regs_cmp[i] >= 4) begin codes.push_back(regs_cmp[i]); his.push_back(1'b1); end
            end
        end
        if (zd) zdiv_stb = 1'b1; else illegal_stb = 1'b1;
        if (with_tst) begin test_stb = 1'b1; test_mask = 8'hFF; end
        step();
        zdiv_stb = 1'b0; illegal_stb = 1'b0; test_stb = 1'b0;
        if (with_tst) md_m[7:6] = 2'b00;
        if (zd) md_m[7] = 1'b1; else md_m[6] = 1'b1;
        chk(mode_status == md_m, with_tst ? "R4" : "R3", "flag after fault", mode_status, md_m);
        for (int k = 0; k < codes.size(); k++) begin
            chk(push_valid == 1'b1, rq, "push_valid", push_valid, 1);
            chk(push_reg == codes[k][3:0], rq, "push_reg", push_reg, codes[k]);
            chk(push_hi == his[k], "R7", "push_hi", push_hi, his[k]);
            if (k == inject_at) begin
                zdiv_stb = 1'b1; ld_stb = 1'b1; ld_data = 8'h01;
                step();
                zdiv_stb = 1'b0; ld_stb = 1'b0;
                md_m[7] = 1'b1; md_m[1:0] = 2'b01;
            end else begin
                step();
            end
        end
        chk(vec_valid && trap_done && !push_valid, "R8", "vector cycle", {vec_valid, trap_done, push_valid}, 3'b110);
        chk(vec_addr == 16'hFFF0, "R8", "vec_addr", vec_addr, 16'hFFF0);
        step();
        chk(!trap_busy && !push_valid && !vec_valid && !trap_done, "R9", "idle after vector",
            {trap_busy, push_valid, vec_valid, trap_done}, 0);
        if (inject_at >= 0)
            chk(mode_status == md_m, "R9", "flag from fault during trap", mode_status, md_m);
    endtask

    task automatic load_mode(input logic [7:0] v);
        ld_stb = 1'b1; ld_data = v;
        step();
        ld_stb = 1'b0;
        md_m[1:0] = v[1:0];
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] a;
        repeat (3) step();
        // R1 reset state
        chk(mode_status == 8'h00, "R1", "mode after reset", mode_status, 0);
        chk(!trap_busy && !push_valid && !vec_valid && !trap_done, "R1", "idle after reset",
            {trap_busy, push_valid, vec_valid, trap_done}, 0);
        rst_n = 1'b1;
        step();
        chk(mode_status == 8'h00 && !native_mode, "R1", "compat mode out of reset", mode_status, 0);

        // R2 sweep of the load immediate, flags clear
        for (int v = 0; v < 256; v++) begin
            load_mode(v[7:0]);
            chk(mode_status == md_m, "R2", "load value", mode_status, md_m);
            chk(native_mode == v[0] && firq_as_irq == v[1], "R2", "mode pins",
                {native_mode, firq_as_irq}, {v[0], v[1]});
        end

        // R3/R4/R5/R6: every flag pair, mode pair and mask
        for (int f = 0; f < 4; f++) begin
            for (int m = 0; m < 256; m++) begin
                load_mode(8'(f));
                if (f[1]) do_trap(1'b1, 1'b0, -1);
                if (f[0]) do_trap(1'b0, 1'b0, -1);
                if (f[1]) begin
                    load_mode(8'hFC);
                    chk(mode_status[7] == 1'b1, "R3", "zdiv flag sticky over load", mode_status, md_m);
                    load_mode(8'(f));
                end
                a = md_m & m[7:0];
                test_stb = 1'b1; test_mask = m[7:0];
                step();
                test_stb = 1'b0;
                md_m[7:6] = 2'b00;
                chk(test_valid == 1'b1, "R4", "test_valid", test_valid, 1);
                chk(test_zero == (a == 8'h00), "R4", "test_zero", test_zero, (a == 8'h00));
                chk(test_neg == a[7], "R4", "test_neg", test_neg, a[7]);
                chk(mode_status == md_m, "R4", "flags cleared", mode_status, md_m);
                step();
                chk(test_valid == 1'b0, "R4", "test_valid pulse", test_valid, 0);
            end
        end

        // R9: fault and mode change in the middle of a compatibility save
        load_mode(8'h00);
        do_trap(1'b0, 1'b0, 3);
        // R9: same during a native save (last byte)
        load_mode(8'h01);
        do_trap(1'b1, 1'b0, 13);
        // R4: test coinciding with a fault keeps that fault's flag
        load_mode(8'h00);
        do_trap(1'b0, 1'b1, -1);
        chk(mode_status[6] == 1'b1 && mode_status[7] == 1'b0, "R4", "fault beats test clear",
            mode_status, md_m);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule